// File: doc/BRIEF.md
# Movable-Window Register File

This block provides a bank of sixteen 16-bit working registers that does not sit at a fixed place. The bank is a window into a larger word-addressed RAM, and a base register (the context base, `cp`) says where the window currently starts. Register number n is the RAM word at `cp + n`, with the sum wrapping at the size of the RAM. Because the registers are ordinary RAM words, a whole bank change is just a new value in `cp`. Two windows whose bases differ by fewer than sixteen words overlap, so a caller can leave arguments in its top registers and a callee finds them in its bottom ones without any copying.

The block supports two ways to change context. An absolute switch saves the current base and loads a base given with the command. A stack-relative switch takes the new bank from the top of a downward-growing stack: the new base is the stack pointer minus the bank size, and the stack pointer moves down to the new base. A return restores the most recent saved base and gives back any stack words that the matching switch claimed. Saved entries are kept in a small internal last-in first-out store, and sticky flags record a switch that found it full and a return that found it empty. The block has two registered read ports and one write port, all indexed by register number.

Top module: `ctx_window_regfile`

## Requirements
- R1: After a synchronous reset, `cp` is 0, `sp` is SP_INIT (240 by default), `ovf` and `unf` are 0, and both read data outputs are 0.
- R2: Register index n on any port maps to RAM word (cp + n) modulo 2^ADDR_W. Read data appears one clock after the index is presented. A read of the word that is written in the same cycle returns the value from before that write.
- R3: A write or a read issued in the same cycle as a switch or a return uses the base that was in force before the command. The new base applies from the next cycle on.
- R4: An absolute switch (`abs_en`) loads `cp` from `abs_base` on the next cycle, saves the old `cp` with a released size of 0, and leaves `sp` unchanged.
- R5: A stack-relative switch (`stk_en`) uses a bank size of `stk_size_m1` + 1, from 1 to 16. On the next cycle `cp` and `sp` both equal the old `sp` minus the size, and the old `cp` is saved together with that size.
- R6: A return (`ret_en`) sets `cp` to the most recently saved base that has not yet been restored, and it adds that entry's size to `sp`. The size is 0 for an entry saved by an absolute switch.
- R7: If the callee's base is the caller's base plus k, then callee register 0 and caller register k are the same RAM word. So with k = 6, caller R6/R7 equal callee R0/R1.
- R8: A switch issued while LIFO_DEPTH entries (4 by default) are saved changes neither `cp` nor `sp`. It sets `ovf`, and `ovf` stays at 1 until reset.
- R9: A return issued with no saved entry changes neither `cp` nor `sp`. It sets `unf`, and `unf` stays at 1 until reset.
- R10: When several commands are asserted in one cycle, only one of them acts: a return ahead of a stack-relative switch, and a stack-relative switch ahead of an absolute switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Register index, read port A |
| rd_b_idx | input | 4 | Register index, read port B |
| rd_a_data | output | 16 | Registered read data, port A |
| rd_b_data | output | 16 | Registered read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 16 | Write data |
| abs_en | input | 1 | Absolute context switch |
| abs_base | input | 8 | New base for an absolute switch |
| stk_en | input | 1 | Stack-relative context switch |
| stk_size_m1 | input | 4 | Bank size minus one for a stack-relative switch |
| ret_en | input | 1 | Restore the previous context |
| cp | output | 8 | Current context base |
| sp | output | 8 | Current stack pointer |
| ovf | output | 1 | Sticky: a switch found the save store full |
| unf | output | 1 | Sticky: a return found the save store empty |

## Verification
The hardest cases to reach are the ones where a command arrives in the same cycle as a write, and the ones where the save store is at its limit. The first case shows whether the old base is used. The second checks that an ignored command leaves both pointers alone. The stimulus first builds known data at a base. It then issues a switch together with a write and returns later to read that word through the original base. It nests switches until the store is full, then pushes one more, then unwinds one entry past empty. The aliasing of overlapping windows is shown by data: values written as caller registers are read back through callee indices after an absolute switch to the caller's base plus six.

// File: rtl/ctxwin_pkg.sv
package ctxwin_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ABS  = 2'd1,
    CMD_STK  = 2'd2,
    CMD_RET  = 2'd3
  } ctx_cmd_e;

  // Fixed priority: return, then stack-relative, then absolute.
  function automatic ctx_cmd_e pick_cmd(input logic ret_req, input logic stk_req,
                                        input logic abs_req);
    if (ret_req)      return CMD_RET;
    else if (stk_req) return CMD_STK;
    else if (abs_req) return CMD_ABS;
    else              return CMD_NONE;
  endfunction

endpackage

// File: rtl/ctxwin_ram.sv
module ctxwin_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NRD    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
  output logic [NRD-1:0][DATA_W-1:0]   rdata
);
  localparam int WORDS = 1 << ADDR_W;

  // One simple dual-port copy per read port. The read is synchronous and
  // read-first, so a same-cycle write is not visible yet.
  for (genvar p = 0; p < NRD; p++) begin : g_copy
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst) rdata[p] <= '0;
      else     rdata[p] <= mem[raddr[p]];
    end
  end

endmodule

// File: rtl/ctxwin_lifo.sv
module ctxwin_lifo #(
  parameter int ENT_W = 13,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] push_data,
  output logic [ENT_W-1:0] top_data,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             unf
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] slots [DEPTH];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] top_pos;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign top_pos = count - CNT_W'(1);
  assign top_data = empty ? '0 : slots[top_pos[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (push && !pop && !full) slots[count[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (pop) begin
      if (empty) unf <= 1'b1;
      else       count <= count - CNT_W'(1);
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ctxwin_ctrl.sv
module ctxwin_ctrl
  import ctxwin_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SZ_W    = 5,
  parameter int IDX_W   = 4,
  parameter int SP_INIT = 240
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     abs_en,
  input  logic [ADDR_W-1:0]        abs_base,
  input  logic                     stk_en,
  input  logic [IDX_W-1:0]         stk_size_m1,
  input  logic                     ret_en,
  input  logic                     full,
  input  logic                     empty,
  input  logic [ADDR_W+SZ_W-1:0]   top_data,
  output logic                     push,
  output logic                     pop,
  output logic [ADDR_W+SZ_W-1:0]   push_data,
  output logic [ADDR_W-1:0]        cp_q,
  output logic [ADDR_W-1:0]        sp_q
);
  ctx_cmd_e           cmd;
  logic [SZ_W-1:0]    bank_sz;
  logic [ADDR_W-1:0]  stk_base;
  logic [ADDR_W-1:0]  saved_cp;
  logic [SZ_W-1:0]    saved_sz;

  always_comb begin
    cmd      = pick_cmd(ret_en, stk_en, abs_en);
    bank_sz  = SZ_W'(stk_size_m1) + SZ_W'(1);
    stk_base = sp_q - ADDR_W'(bank_sz);
    push     = (cmd == CMD_STK) || (cmd == CMD_ABS);
    pop      = (cmd == CMD_RET);
    push_data = {cp_q, (cmd == CMD_STK) ? bank_sz : SZ_W'(0)};
    saved_cp = top_data[ADDR_W+SZ_W-1:SZ_W];
    saved_sz = top_data[SZ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_q <= '0;
      sp_q <= ADDR_W'(SP_INIT);
    end else begin
      case (cmd)
        CMD_RET: if (!empty) begin
          cp_q <= saved_cp;
          sp_q <= sp_q + ADDR_W'(saved_sz);
        end
        CMD_STK: if (!full) begin
          cp_q <= stk_base;
          sp_q <= stk_base;
        end
        CMD_ABS: if (!full) cp_q <= abs_base;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ctx_window_regfile.sv
module ctx_window_regfile #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int NREG       = 16,
  parameter int LIFO_DEPTH = 4,
  parameter int SP_INIT    = 240
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(NREG)-1:0]    rd_a_idx,
  input  logic [$clog2(NREG)-1:0]    rd_b_idx,
  output logic [DATA_W-1:0]          rd_a_data,
  output logic [DATA_W-1:0]          rd_b_data,
  input  logic                       wr_en,
  input  logic [$clog2(NREG)-1:0]    wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       abs_en,
  input  logic [ADDR_W-1:0]          abs_base,
  input  logic                       stk_en,
  input  logic [$clog2(NREG)-1:0]    stk_size_m1,
  input  logic                       ret_en,
  output logic [ADDR_W-1:0]          cp,
  output logic [ADDR_W-1:0]          sp,
  output logic                       ovf,
  output logic                       unf
);
  localparam int IDX_W = $clog2(NREG);
  localparam int SZ_W  = IDX_W + 1;
  localparam int ENT_W = ADDR_W + SZ_W;
  localparam int NRD   = 2;

  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][ADDR_W-1:0] rd_addr;
  logic [NRD-1:0][DATA_W-1:0] rd_q;
  logic [ADDR_W-1:0]          wr_addr;
  logic                       lifo_push, lifo_pop, lifo_full, lifo_empty;
  logic [ENT_W-1:0]           lifo_in, lifo_top;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  // Base plus index; the sum wraps at the RAM size.
  for (genvar p = 0; p < NRD; p++) begin : g_radr
    assign rd_addr[p] = cp + ADDR_W'(rd_idx[p]);
  end
  assign wr_addr = cp + ADDR_W'(wr_idx);

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];

  ctxwin_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NRD(NRD)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_q)
  );

  ctxwin_lifo #(.ENT_W(ENT_W), .DEPTH(LIFO_DEPTH)) u_lifo (
    .clk(clk), .rst(rst), .push(lifo_push), .pop(lifo_pop), .push_data(lifo_in),
    .top_data(lifo_top), .full(lifo_full), .empty(lifo_empty), .ovf(ovf), .unf(unf)
  );

  ctxwin_ctrl #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W), .SP_INIT(SP_INIT)) u_ctrl (
    .clk(clk), .rst(rst), .abs_en(abs_en), .abs_base(abs_base), .stk_en(stk_en),
    .stk_size_m1(stk_size_m1), .ret_en(ret_en), .full(lifo_full), .empty(lifo_empty),
    .top_data(lifo_top), .push(lifo_push), .pop(lifo_pop), .push_data(lifo_in),
    .cp_q(cp), .sp_q(sp)
  );

endmodule

// File: rtl/ctxwin_checker.sv
module ctxwin_checker #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    abs_en,
  input logic [ADDR_W-1:0]       abs_base,
  input logic                    stk_en,
  input logic [$clog2(NREG)-1:0] stk_size_m1,
  input logic                    ret_en,
  input logic [ADDR_W-1:0]       cp,
  input logic [ADDR_W-1:0]       sp,
  input logic                    ovf,
  input logic                    unf,
  input logic                    lifo_full,
  input logic                    lifo_empty
);
  logic [ADDR_W-1:0] stk_target;
  assign stk_target = sp - ADDR_W'(stk_size_m1) - ADDR_W'(1);

  // R4: accepted absolute switch
  a_r4_abs_load: assert property (@(posedge clk) disable iff (rst)
    (abs_en && !stk_en && !ret_en && !lifo_full) |=> (cp == $past(abs_base)) && $stable(sp));

  // R5: accepted stack-relative switch
  a_r5_stk_carve: assert property (@(posedge clk) disable iff (rst)
    (stk_en && !ret_en && !lifo_full) |=> (cp == $past(stk_target)) && (sp == cp));

  // R8: a switch into a full store is ignored and flagged
  a_r8_full_ignored: assert property (@(posedge clk) disable iff (rst)
    ((abs_en || stk_en) && !ret_en && lifo_full) |=> ovf && $stable(cp) && $stable(sp));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R9: a return with nothing saved is ignored and flagged
  a_r9_empty_ignored: assert property (@(posedge clk) disable iff (rst)
    (ret_en && lifo_empty) |=> unf && $stable(cp) && $stable(sp));

  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);

  // R10: a return wins; a switch raised with it does not count as a push
  a_r10_ret_first: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !lifo_empty && (abs_en || stk_en)) |=> !ovf || $past(ovf));

endmodule

bind ctx_window_regfile ctxwin_checker #(.ADDR_W(ADDR_W), .NREG(NREG)) u_ctxwin_checker (.*);

// File: tb/test_ctx_window_regfile.sv
`timescale 1ns/1ps
module test_ctx_window_regfile;
  localparam int DW = 16, AW = 8, DEPTH = 4, SPI = 240, WORDS = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, stk_size_m1 = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 1'b0, abs_en = 1'b0, stk_en = 1'b0, ret_en = 1'b0;
  logic [AW-1:0] abs_base = '0, cp, sp;
  logic ovf, unf;

  always #4 clk = ~clk;

  ctx_window_regfile i_ctx_window_regfile (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .abs_en(abs_en), .abs_base(abs_base), .stk_en(stk_en),
    .stk_size_m1(stk_size_m1), .ret_en(ret_en), .cp(cp), .sp(sp), .ovf(ovf), .unf(unf)
  );

  int errors = 0, checks = 0;
  string req = "R1";
  int m_cp, m_sp, m_mem[WORDS];
  bit m_vld[WORDS];
  int m_saves[$];
  bit m_ovf, m_unf, va, vb;
  int ea, eb;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("cp", int'(cp), m_cp);
    chk("sp", int'(sp), m_sp);
    chk("ovf", int'(ovf), int'(m_ovf));
    chk("unf", int'(unf), int'(m_unf));
    if (va) chk("rd_a_data", int'(rd_a_data), ea);
    if (vb) chk("rd_b_data", int'(rd_b_data), eb);
  endtask

  // Model the coming edge from the inputs now driven, then check after it.
  task automatic tick();
    int a, b, e;
    a = (m_cp + int'(rd_a_idx)) % WORDS;
    b = (m_cp + int'(rd_b_idx)) % WORDS;
    va = m_vld[a]; ea = m_mem[a];
    vb = m_vld[b]; eb = m_mem[b];
    if (wr_en) begin
      m_mem[(m_cp + int'(wr_idx)) % WORDS] = int'(wr_data);
      m_vld[(m_cp + int'(wr_idx)) % WORDS] = 1'b1;
    end
    if (ret_en) begin
      if (m_saves.size() == 0) m_unf = 1'b1;
      else begin
        e = m_saves.pop_back();
        m_cp = e / 32;
        m_sp = (m_sp + e % 32) % WORDS;
      end
    end else if (stk_en) begin
      if (m_saves.size() == DEPTH) m_ovf = 1'b1;
      else begin
        e = int'(stk_size_m1) + 1;
        m_saves.push_back(m_cp * 32 + e);
        m_cp = (m_sp - e + WORDS) % WORDS;
        m_sp = m_cp;
      end
    end else if (abs_en) begin
      if (m_saves.size() == DEPTH) m_ovf = 1'b1;
      else begin
        m_saves.push_back(m_cp * 32);
        m_cp = int'(abs_base);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = 0; abs_en = 0; stk_en = 0; ret_en = 0;
  endtask

  task automatic wr(int idx, int val);
    wr_en = 1; wr_idx = 4'(idx); wr_data = DW'(val);
    tick();
  endtask

  task automatic rd(int ia, int ib);
    rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
    tick();
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_cp = 0; m_sp = SPI; m_ovf = 0; m_unf = 0;
    va = 1; vb = 1; ea = 0; eb = 0;
    req = "R1"; compare();

    // R2: base plus index, one-cycle read latency, read-first on collision
    req = "R2";
    for (int i = 0; i < 16; i++) wr(i, 16'hA000 + i * 17);
    for (int i = 0; i < 16; i++) rd(i, 15 - i);
    rd_a_idx = 3; rd_b_idx = 3;
    wr(3, 16'h5A5A);
    rd(3, 0);

    // R4: absolute switch loads the base, sp untouched
    req = "R4";
    abs_en = 1; abs_base = 8'h40; tick();
    wr(6, 16'h1234); wr(7, 16'hBEEF); wr(0, 16'h0F0F);
    rd(6, 7);
    // R7: callee base = caller base + 6 aliases R6/R7 onto R0/R1
    req = "R7";
    abs_en = 1; abs_base = 8'h46; tick();
    rd(0, 1);
    wr(0, 16'h7777);
    // R6: return restores the caller base
    req = "R6";
    ret_en = 1; tick();
    rd(6, 0);
    ret_en = 1; tick();
    rd(3, 15);

    // R3: write and read in the switch cycle still use the old base
    req = "R3";
    rd_a_idx = 2; abs_en = 1; abs_base = 8'h80; wr(2, 16'hC0DE);
    rd(2, 5);
    ret_en = 1; rd_a_idx = 5; wr(5, 16'hD00D);
    rd(2, 5);

    // R5: stack-relative banks carved below sp
    req = "R5";
    stk_en = 1; stk_size_m1 = 3; tick();
    wr(0, 16'h1111); wr(3, 16'h3333);
    stk_en = 1; stk_size_m1 = 15; tick();
    wr(15, 16'hFFFF);
    rd(15, 0);
    req = "R6";
    ret_en = 1; tick();
    rd(0, 3);
    ret_en = 1; tick();

    // R10: return beats both switches, stack-relative beats absolute
    req = "R10";
    abs_en = 1; abs_base = 8'h20; tick();
    ret_en = 1; stk_en = 1; abs_en = 1; abs_base = 8'h90; stk_size_m1 = 1; tick();
    stk_en = 1; abs_en = 1; abs_base = 8'h90; stk_size_m1 = 1; tick();
    ret_en = 1; tick();

    // R8: fill the save store, then one more switch of each kind
    req = "R8";
    for (int i = 0; i < DEPTH; i++) begin
      abs_en = 1; abs_base = AW'(16 * (i + 1)); tick();
    end
    abs_en = 1; abs_base = 8'hEE; tick();
    stk_en = 1; stk_size_m1 = 7; tick();
    rd(0, 0);

    // R9: unwind past empty
    req = "R9";
    for (int i = 0; i < DEPTH; i++) begin ret_en = 1; tick(); end
    ret_en = 1; tick();
    rd(1, 2);

    // R2: window wraps around the top of the RAM
    req = "R2";
    abs_en = 1; abs_base = 8'd250; tick();
    wr(10, 16'h4444);
    rd(10, 5);
    ret_en = 1; tick();
    rd(4, 6);
    tick();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule